// File: doc/BRIEF.md
# Segmented Backplane Window Translator

This block sits on the device side of a card-bus host interface and lets the host reach any location of a 32-bit internal backplane through a small 2 KB memory window. Software picks a backplane slot by writing three byte-wide base registers in a byte-addressed configuration space. It picks the lower or upper 2 KB half of that 4 KB slot with a one-bit segment register. Every register reads back exactly what it stores, so software can confirm that a slot or segment switch has taken effect before it touches the window.

Each host access into the window becomes backplane traffic on a 16-bit data path. The full byte address is formed from the slot base, the segment bit and the 11-bit window offset. Byte accesses drive a single byte lane chosen by offset bit 0. Halfword accesses take one 16-bit beat. Word accesses take two beats: the low half at the offset and the high half two bytes above it. Each beat is held on the backplane until it is acknowledged, and the host sees a one-cycle completion pulse with the assembled read data.

Top module: `bpWindowXlate`

## Requirements
- R1: Configuration offset 0x2E stores backplane address bits 15:12 from write-data bits 3:0. Reading it returns them in bits 3:0, with bits 7:4 reading 0.
- R2: Configuration offset 0x30 stores address bits 23:16 and offset 0x32 stores bits 31:24. Both read back the full written byte.
- R3: Configuration offset 0x34 is the segment register. It stores write-data bit 0 and reads back as 0 or 1. Any other configuration offset reads 0. All registers reset to 0.
- R4: The backplane byte address of an access is {base[31:24], base[23:16], nibble[3:0], segment, offset[10:0]}, i.e. slot base + segment*0x800 + offset.
- R5: A byte access (hostSize 0) makes one beat with bpByteEn 2'b01 for even offsets and 2'b10 for odd ones (bit 0 is the low lane, data bits 7:0). The write byte is copied onto both lanes. The read result is the selected lane, zero-extended.
- R6: A halfword access (hostSize 1) makes one beat with bpByteEn 2'b11. Write data is hostWrData[15:0], and the read result is the beat data zero-extended.
- R7: A word access (hostSize 2 or 3) makes two beats: the first at the R4 address with hostWrData[15:0], the second at that address + 2 with hostWrData[31:16], with carry into the higher bits. The read result is {second beat, first beat}.
- R8: While a beat waits for bpAck, bpReq stays high and bpAddr stays constant. No bpReq is raised while the block is idle. hostDone pulses for exactly one cycle, one cycle after the last acknowledged beat.
- R9: Base and segment are sampled when a request is accepted. Configuration writes made during an access do not change the addresses of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data (combinational) |
| hostReq | input | 1 | Window access request, taken when idle |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| hostOffset | input | 11 | Byte offset inside the window |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, valid with hostDone |
| hostBusy | output | 1 | Access in progress |
| hostDone | output | 1 | One-cycle completion pulse |
| bpReq | output | 1 | Backplane beat request |
| bpWe | output | 1 | Backplane beat direction |
| bpAddr | output | 32 | Backplane byte address |
| bpByteEn | output | 2 | Byte lane enables |
| bpWrData | output | 16 | Backplane write data |
| bpRdData | input | 16 | Backplane read data |
| bpAck | input | 1 | Beat acknowledge |

## Verification
The assertions check on every cycle that a waiting beat holds its request and address, that no beat appears while idle, that the completion pulse is one cycle long and follows an acknowledge, that lane enables are never empty, and that the nibble and segment registers never read back stray upper bits. Address formation, lane selection, write-data placement, read-data assembly, the carry across the slot boundary on a word's second half, and the sampling of the base at acceptance can only be shown by the bench. It sweeps slot bases, both segments, edge offsets, all sizes, both directions and varying acknowledge delays against arithmetically computed addresses and data.

// File: rtl/bpwin_pkg.sv
package bpwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } winState_e;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // accept host request, sample base and segment
    logic latchLo;   // first beat acknowledged
    logic latchHi;   // second beat acknowledged
    logic beatHi;    // second beat on the bus
  } winStrobe_t;

endpackage

// File: rtl/bpWinRegs.sv
module bpWinRegs #(
  parameter int CFG_AW = 8,
  parameter int NIB_W = 4,
  parameter logic [CFG_AW-1:0] OFF_BASE0 = 8'h2E,
  parameter logic [CFG_AW-1:0] OFF_BASE1 = 8'h30,
  parameter logic [CFG_AW-1:0] OFF_BASE2 = 8'h32,
  parameter logic [CFG_AW-1:0] OFF_SEG = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  output logic [NIB_W-1:0]  baseNib,
  output logic [7:0]        baseMid,
  output logic [7:0]        baseTop,
  output logic              segSel
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseNib <= '0;
      baseMid <= '0;
      baseTop <= '0;
      segSel  <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgAddr == OFF_BASE0) baseNib <= cfgWrData[NIB_W-1:0];
      if (cfgAddr == OFF_BASE1) baseMid <= cfgWrData;
      if (cfgAddr == OFF_BASE2) baseTop <= cfgWrData;
      if (cfgAddr == OFF_SEG)   segSel  <= cfgWrData[0];
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgAddr == OFF_BASE0)      cfgRdData[NIB_W-1:0] = baseNib;
    else if (cfgAddr == OFF_BASE1) cfgRdData = baseMid;
    else if (cfgAddr == OFF_BASE2) cfgRdData = baseTop;
    else if (cfgAddr == OFF_SEG)   cfgRdData[0] = segSel;
  end

endmodule

// File: rtl/bpWinCtrl.sv
module bpWinCtrl
  import bpwin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       capWord,
  input  logic       bpAck,
  output winStrobe_t strb,
  output logic       bpReq,
  output logic       hostBusy,
  output logic       hostDone
);

  winState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    bpReq    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (hostReq) begin
          strb.capture = 1'b1;
          stateNxt     = ST_LO;
        end
      end
      ST_LO: begin
        bpReq = 1'b1;
        if (bpAck) begin
          strb.latchLo = 1'b1;
          stateNxt     = capWord ? ST_HI : ST_FIN;
        end
      end
      ST_HI: begin
        bpReq       = 1'b1;
        strb.beatHi = 1'b1;
        if (bpAck) begin
          strb.latchHi = 1'b1;
          stateNxt     = ST_FIN;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign hostBusy = (state != ST_IDLE);
  assign hostDone = (state == ST_FIN);

endmodule

// File: rtl/bpWinDatapath.sv
module bpWinDatapath
  import bpwin_pkg::*;
#(
  parameter int WIN_AW = 11,
  parameter int NIB_W = 4,
  parameter int BP_AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strb,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [WIN_AW-1:0] hostOffset,
  input  logic [31:0]       hostWrData,
  input  logic [NIB_W-1:0]  baseNib,
  input  logic [7:0]        baseMid,
  input  logic [7:0]        baseTop,
  input  logic              segSel,
  input  logic [15:0]       bpRdData,
  output logic [BP_AW-1:0]  bpAddr,
  output logic              bpWe,
  output logic [1:0]        bpByteEn,
  output logic [15:0]       bpWrData,
  output logic [31:0]       hostRdData,
  output logic              capWord
);

  logic [BP_AW-1:0] capAddr;
  logic [1:0]       capSize;
  logic             capWe;
  logic [31:0]      capData;
  logic [15:0]      rdLo;
  logic             isByte;
  logic [7:0]       laneByte;

  // base bits, segment bit and offset occupy disjoint fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= '0;
      capSize <= '0;
      capWe   <= 1'b0;
      capData <= '0;
    end else if (strb.capture) begin
      capAddr <= {baseTop, baseMid, baseNib, segSel, hostOffset};
      capSize <= hostSize;
      capWe   <= hostWe;
      capData <= hostWrData;
    end
  end

  assign isByte  = (capSize == SIZE_BYTE);
  assign capWord = capSize[1];

  assign bpAddr = strb.beatHi ? capAddr + BP_AW'(2) : capAddr;
  assign bpWe   = capWe;

  always_comb begin
    if (isByte) begin
      bpByteEn = capAddr[0] ? 2'b10 : 2'b01;
      bpWrData = {2{capData[7:0]}};
    end else begin
      bpByteEn = 2'b11;
      bpWrData = strb.beatHi ? capData[31:16] : capData[15:0];
    end
  end

  assign laneByte = capAddr[0] ? bpRdData[15:8] : bpRdData[7:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLo       <= '0;
      hostRdData <= '0;
    end else if (!capWe) begin
      if (strb.latchLo) begin
        rdLo <= bpRdData;
        if (isByte)        hostRdData <= {24'h0, laneByte};
        else if (!capWord) hostRdData <= {16'h0, bpRdData};
      end
      if (strb.latchHi) hostRdData <= {bpRdData, rdLo};
    end
  end

endmodule

// File: rtl/bpWindowXlate.sv
module bpWindowXlate
  import bpwin_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int WIN_AW = 11,
  parameter logic [CFG_AW-1:0] OFF_BASE0 = 8'h2E,
  parameter logic [CFG_AW-1:0] OFF_BASE1 = 8'h30,
  parameter logic [CFG_AW-1:0] OFF_BASE2 = 8'h32,
  parameter logic [CFG_AW-1:0] OFF_SEG = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [WIN_AW-1:0] hostOffset,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              hostBusy,
  output logic              hostDone,
  output logic              bpReq,
  output logic              bpWe,
  output logic [31:0]       bpAddr,
  output logic [1:0]        bpByteEn,
  output logic [15:0]       bpWrData,
  input  logic [15:0]       bpRdData,
  input  logic              bpAck
);

  localparam int SLOT_LSB = WIN_AW + 1;
  localparam int NIB_W = 16 - SLOT_LSB;
  localparam int BP_AW = 16 + 16;

  winStrobe_t       strb;
  logic [NIB_W-1:0] baseNib;
  logic [7:0]       baseMid;
  logic [7:0]       baseTop;
  logic             segSel;
  logic             capWord;

  bpWinRegs #(
    .CFG_AW(CFG_AW), .NIB_W(NIB_W),
    .OFF_BASE0(OFF_BASE0), .OFF_BASE1(OFF_BASE1),
    .OFF_BASE2(OFF_BASE2), .OFF_SEG(OFF_SEG)
  ) u_regs (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .baseNib(baseNib),
    .baseMid(baseMid), .baseTop(baseTop), .segSel(segSel)
  );

  bpWinCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .capWord(capWord),
    .bpAck(bpAck), .strb(strb), .bpReq(bpReq), .hostBusy(hostBusy),
    .hostDone(hostDone)
  );

  bpWinDatapath #(.WIN_AW(WIN_AW), .NIB_W(NIB_W), .BP_AW(BP_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWe(hostWe),
    .hostSize(hostSize), .hostOffset(hostOffset), .hostWrData(hostWrData),
    .baseNib(baseNib), .baseMid(baseMid), .baseTop(baseTop),
    .segSel(segSel), .bpRdData(bpRdData), .bpAddr(bpAddr), .bpWe(bpWe),
    .bpByteEn(bpByteEn), .bpWrData(bpWrData), .hostRdData(hostRdData),
    .capWord(capWord)
  );

endmodule

// File: rtl/bpWindowXlate_chk.sv
module bpWindowXlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostBusy,
  input logic        hostDone,
  input logic        bpReq,
  input logic        bpAck,
  input logic [31:0] bpAddr,
  input logic [1:0]  bpByteEn,
  input logic [7:0]  cfgAddr,
  input logic [7:0]  cfgRdData
);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (bpReq && !bpAck) |=> (bpReq && $stable(bpAddr))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !hostBusy |-> !bpReq); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone); // R8

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostDone) |-> $past(bpReq && bpAck)); // R8

  AST_LANE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    bpReq |-> (bpByteEn != 2'b00)); // R5

  AST_NIBBLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 8'h2E) |-> (cfgRdData[7:4] == 4'h0)); // R1

  AST_SEG_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 8'h34) |-> (cfgRdData[7:1] == 7'h0)); // R3

endmodule

bind bpWindowXlate bpWindowXlate_chk u_chk (
  .clk(clk), .rstN(rstN), .hostBusy(hostBusy), .hostDone(hostDone),
  .bpReq(bpReq), .bpAck(bpAck), .bpAddr(bpAddr), .bpByteEn(bpByteEn),
  .cfgAddr(cfgAddr), .cfgRdData(cfgRdData)
);

// File: tb/bpWindowXlate_tb.sv
`timescale 1ns/1ps
module bpWindowXlate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        hostReq = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSize = '0;
  logic [10:0] hostOffset = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostBusy, hostDone, bpReq, bpWe, bpAck;
  logic [31:0] bpAddr;
  logic [1:0]  bpByteEn;
  logic [15:0] bpWrData, bpRdData;

  int total = 0;
  int bad = 0;
  int waitSet = 0;
  logic [1:0] waitCnt;
  bit finished = 1'b0;

  logic [31:0] logAddr [0:3];
  logic [1:0]  logBe   [0:3];
  logic        logWe   [0:3];
  logic [15:0] logWd   [0:3];
  int          logN;

  always #2 clk = ~clk;

  function automatic logic [15:0] memModel(input logic [31:0] a);
    logic [31:0] al;
    al = {a[31:1], 1'b0};
    return al[15:0] ^ al[31:16] ^ 16'h5A3C;
  endfunction

  assign bpRdData = memModel(bpAddr);
  assign bpAck = bpReq && (int'(waitCnt) >= waitSet);

  always @(posedge clk) begin
    if (!rstN) waitCnt <= '0;
    else if (bpReq && !bpAck) waitCnt <= waitCnt + 2'd1;
    else waitCnt <= '0;
  end

  bpWindowXlate u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic doAccess(input bit we, input logic [1:0] sz, input logic [10:0] off,
                          input logic [31:0] wd, input bit midEn,
                          input logic [7:0] midA, input logic [7:0] midD,
                          output logic [31:0] rd);
    logN = 0;
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostSize = sz; hostOffset = off; hostWrData = wd;
    @(posedge clk);
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      hostReq = 1'b0;
      if (it == 0 && midEn) begin cfgWrEn = 1'b1; cfgAddr = midA; cfgWrData = midD; end
      else cfgWrEn = 1'b0;
      if (bpReq && bpAck && logN < 4) begin
        logAddr[logN] = bpAddr; logBe[logN] = bpByteEn;
        logWe[logN] = bpWe; logWd[logN] = bpWrData;
        logN++;
      end
      if (hostDone) begin rd = hostRdData; break; end
    end
    cfgWrEn = 1'b0;
  endtask

  task automatic verifyTx(input bit we, input logic [1:0] sz, input logic [10:0] off,
                          input logic [31:0] wd, input logic [31:0] expA,
                          input logic [31:0] rd);
    int nExp;
    logic [1:0] beExp;
    logic [15:0] m0, m1;
    nExp = sz[1] ? 2 : 1;
    beExp = (sz == 2'd0) ? (off[0] ? 2'b10 : 2'b01) : 2'b11;
    check(logN == nExp, "R7 beat count", logN, nExp);
    for (int b = 0; b < nExp && b < logN; b++) begin
      check(logAddr[b] == expA + 32'(2*b), "R4 R7 beat address", logAddr[b], expA + 32'(2*b));
      check(logBe[b] == beExp, "R5 R6 byte enables", 32'(logBe[b]), 32'(beExp));
      check(logWe[b] == we, "R8 beat direction", 32'(logWe[b]), 32'(we));
      if (we) begin
        if (sz == 2'd0)
          check(logWd[b] == {2{wd[7:0]}}, "R5 byte write lanes", 32'(logWd[b]), 32'({2{wd[7:0]}}));
        else if (b == 0)
          check(logWd[b] == wd[15:0], "R6 R7 low write half", 32'(logWd[b]), 32'(wd[15:0]));
        else
          check(logWd[b] == wd[31:16], "R7 high write half", 32'(logWd[b]), 32'(wd[31:16]));
      end
    end
    if (!we) begin
      m0 = memModel(expA);
      m1 = memModel(expA + 32'd2);
      if (sz == 2'd0)
        check(rd == {24'h0, off[0] ? m0[15:8] : m0[7:0]}, "R5 byte read", rd,
              {24'h0, off[0] ? m0[15:8] : m0[7:0]});
      else if (!sz[1])
        check(rd == {16'h0, m0}, "R6 half read", rd, {16'h0, m0});
      else
        check(rd == {m1, m0}, "R7 word read", rd, {m1, m0});
    end
  endtask

  function automatic logic [10:0] offPick(input int i);
    case (i)
      0: return 11'h000;
      1: return 11'h001;
      2: return 11'h2A4;
      3: return 11'h555;
      4: return 11'h7FE;
      default: return 11'h7FF;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R8 watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [31:0] rd, expA, wd;
    logic [7:0] tB, mB;
    logic [3:0] nB;
    int k = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state (R3)
    cfgRead(8'h2E, rv); check(rv == 8'h00, "R3 reset nibble", 32'(rv), 0);
    cfgRead(8'h30, rv); check(rv == 8'h00, "R3 reset mid", 32'(rv), 0);
    cfgRead(8'h32, rv); check(rv == 8'h00, "R3 reset top", 32'(rv), 0);
    cfgRead(8'h34, rv); check(rv == 8'h00, "R3 reset segment", 32'(rv), 0);
    check(!hostBusy && !bpReq && !hostDone, "R8 idle after reset",
          {29'h0, hostBusy, bpReq, hostDone}, 0);
    // R1 nibble masking
    cfgWrite(8'h2E, 8'hF7); cfgRead(8'h2E, rv); check(rv == 8'h07, "R1 nibble readback", 32'(rv), 32'h07);
    // R2 full bytes
    cfgWrite(8'h30, 8'hA5); cfgRead(8'h30, rv); check(rv == 8'hA5, "R2 mid readback", 32'(rv), 32'hA5);
    cfgWrite(8'h32, 8'h3C); cfgRead(8'h32, rv); check(rv == 8'h3C, "R2 top readback", 32'(rv), 32'h3C);
    // R3 segment stores bit 0 only, unmapped reads 0
    cfgWrite(8'h34, 8'hFF); cfgRead(8'h34, rv); check(rv == 8'h01, "R3 segment bit0", 32'(rv), 1);
    cfgWrite(8'h34, 8'hFE); cfgRead(8'h34, rv); check(rv == 8'h00, "R3 segment clear", 32'(rv), 0);
    cfgWrite(8'h2F, 8'h55); cfgRead(8'h2F, rv); check(rv == 8'h00, "R3 unmapped reads zero", 32'(rv), 0);
    cfgRead(8'h2E, rv); check(rv == 8'h07, "R3 unmapped write no effect", 32'(rv), 32'h07);

    // near-exhaustive sweep: R4 R5 R6 R7 R8
    for (int bi = 0; bi < 4; bi++) begin
      tB = 8'(8'h18 + bi * 8'h47);
      mB = 8'(8'hC3 - bi * 8'h29);
      nB = 4'(bi * 5);
      cfgWrite(8'h32, tB);
      cfgWrite(8'h30, mB);
      cfgWrite(8'h2E, {4'hA, nB});
      for (int sg = 0; sg < 2; sg++) begin
        cfgWrite(8'h34, 8'(sg));
        for (int oi = 0; oi < 6; oi++) begin
          for (int sz = 0; sz < 4; sz++) begin
            if (sz != 0 && offPick(oi)[0]) continue;
            for (int we = 0; we < 2; we++) begin
              k++;
              waitSet = k % 3;
              wd = (32'(k) * 32'h01010101) ^ 32'h3C5AF00F;
              expA = (32'(tB) << 24) + (32'(mB) << 16) + (32'(nB) << 12)
                     + 32'(sg) * 32'h800 + 32'(offPick(oi));
              rd = '0;
              doAccess(we[0], 2'(sz), offPick(oi), wd, 1'b0, 8'h0, 8'h0, rd);
              verifyTx(we[0], 2'(sz), offPick(oi), wd, expA, rd);
            end
          end
        end
      end
    end

    // R9: config writes during a word read do not move its addresses
    cfgWrite(8'h32, 8'h12); cfgWrite(8'h30, 8'h34); cfgWrite(8'h2E, 8'h05);
    cfgWrite(8'h34, 8'h00);
    waitSet = 2;
    doAccess(1'b0, 2'd2, 11'h100, 32'h0, 1'b1, 8'h30, 8'h99, rd);
    verifyTx(1'b0, 2'd2, 11'h100, 32'h0, 32'h1234_5100, rd);
    cfgRead(8'h30, rv); check(rv == 8'h99, "R9 R2 mid write landed", 32'(rv), 32'h99);
    doAccess(1'b0, 2'd1, 11'h100, 32'h0, 1'b1, 8'h34, 8'h01, rd);
    verifyTx(1'b0, 2'd1, 11'h100, 32'h0, 32'h1299_5100, rd);
    waitSet = 0;
    doAccess(1'b1, 2'd1, 11'h100, 32'hBEEF, 1'b0, 8'h0, 8'h0, rd);
    verifyTx(1'b1, 2'd1, 11'h100, 32'hBEEF, 32'h1299_5900, rd);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule